// File: doc/BRIEF.md
# Priority-free interrupt controller

This block gathers 32 level-sensitive interrupt lines into one external-interrupt request for a single core. Every source is handled at the same priority level. A word-indexed register port gives software four things: read the pending bits, set the enable bits, take an interrupt by reading the claim word, and hand it back by writing the source number to that same word. The port also flags whether the index it was given decodes to a register. The bus wrapper uses that flag to raise an access fault.

Each source passes through a gateway with a mask latch. An active input with a clear mask bit makes the source pending. Any active input sets the mask bit, so a line that stays high cannot post a second request until software completes the first. A claim always returns the lowest-numbered source that is both pending and enabled. The words for per-source priority and for the threshold exist so that software written for a fuller controller still works. They hold fixed values and drop writes.

Top module: `irq_ctrl_lite`

## Requirements
- R1: While reset is asserted, and after reset is released, the pending, enable and mask bits are all 0 and `ext_irq_o` is low.
- R2: `reg_hit_o` is 1 for these word indices and no others: 1 to 31, 0x400, 0x800, 0x80000 and 0x80001. Index 0 and every other index give `reg_hit_o`=0, and reading them returns 0.
- R3: Indices 1 to 31 always read 1. Index 0x80000 always reads 0. Writes to any of these indices change nothing.
- R4: Index 0x800 reads back the enable bits (bit n enables source n). A write stores the write data with bit 0 forced to 0. Index 0x400 returns the pending bits as they stood after the most recent clock edge.
- R5: At every clock edge, a source n in 1..31 becomes pending if its input is high and its mask bit is clear. Every high input sets its own mask bit. Source 0 never becomes pending.
- R6: A source whose mask bit is set does not become pending again, however long its input stays high, until its mask bit is cleared by a completion.
- R7: A read of index 0x80001 returns the lowest source number n ≥ 1 that is both pending and enabled, and clears that pending bit at the same edge. If no source qualifies, the read returns 0 and no pending bit changes. A source that is pending but not enabled is never returned.
- R8: A write of value v to index 0x80001 clears the mask bit of source v, but only when v < 32 and source v is enabled at that moment. Any other value, or a disabled source, leaves every mask bit as it was.
- R9: `ext_irq_o` is high exactly when some source is both pending and enabled, based on the register state after the last edge.
- R10: Claim and complete act after the gateway update of the same cycle. A claim sees a source whose input rises in the claim cycle, and that source is not left pending. A source that is completed while its input stays high becomes pending again one edge after the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive interrupt inputs, bit n is source n |
| reg_idx_i | input | 20 | Register word index |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the current index |
| reg_hit_o | output | 1 | Index decodes to a register |
| ext_irq_o | output | 1 | External interrupt request to the core |

## Verification
The bench targets the mask latch. A held input must stay silent after its claim. A design that cleared the mask on claim, or never set it, would show the source pending again at once. A completion of a disabled source, or of a number of 32 or more, must not unmask anything. A design that ignored the enable, or that decoded only the low bits of the value, would let the next pulse become pending. It also claims in the same cycle as an input rises, and checks that the completion takes one extra edge to show, which exposes any mix-up in the order of gateway and bus actions. Lowest-number selection across widely spaced sources, pending-but-disabled sources, source 0, and every decode boundary (0, 31/32, the indices next to the claim word) complete the set.

// File: rtl/irq_lite_pkg.sv
package irq_lite_pkg;
  localparam int unsigned IDX_W = 20;

  localparam logic [IDX_W-1:0] IDX_PEND  = 20'h00400;
  localparam logic [IDX_W-1:0] IDX_EN    = 20'h00800;
  localparam logic [IDX_W-1:0] IDX_THR   = 20'h80000;
  localparam logic [IDX_W-1:0] IDX_CLAIM = 20'h80001;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } reg_sel_e;
endpackage

// File: rtl/irq_decode.sv
module irq_decode
  import irq_lite_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic [IDX_W-1:0] idx_i,
  output reg_sel_e         sel_o,
  output logic             hit_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (idx_i != '0 && idx_i < IDX_W'(NSRC)) sel_o = SEL_PRIO;
    else if (idx_i == IDX_PEND)              sel_o = SEL_PEND;
    else if (idx_i == IDX_EN)                sel_o = SEL_EN;
    else if (idx_i == IDX_THR)               sel_o = SEL_THR;
    else if (idx_i == IDX_CLAIM)             sel_o = SEL_CLAIM;
  end

  assign hit_o = (sel_o != SEL_NONE);
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] clr_pend_i,
  input  logic [NSRC-1:0] clr_mask_i,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] pend_upd_o
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] no_src0;

  assign no_src0    = {{(NSRC-1){1'b1}}, 1'b0};
  // post-gateway view of this cycle; bus actions apply on top of it
  assign pend_upd_o = (pend_q | (src_i & ~mask_q)) & no_src0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_upd_o & ~clr_pend_i;
      mask_q <= (mask_q | src_i) & ~clr_mask_i;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NSRC = 32,
  localparam int unsigned ID_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] cand_i,
  output logic            found_o,
  output logic [ID_W-1:0] id_o
);
  // descending scan so the lowest set index wins; index 0 never qualifies
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    for (int i = NSRC - 1; i >= 1; i--) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        id_o    = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_lite.sv
module irq_ctrl_lite
  import irq_lite_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ID_W  = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_hit_o,
  output logic              ext_irq_o
);
  reg_sel_e        sel;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_upd;
  logic [NSRC-1:0] clr_pend;
  logic [NSRC-1:0] clr_mask;
  logic            cl_found;
  logic [ID_W-1:0] cl_id;
  logic [ID_W-1:0] cpl_id;
  logic            cpl_ok;

  irq_decode #(.NSRC(NSRC)) u_dec (
    .idx_i (reg_idx_i),
    .sel_o (sel),
    .hit_o (reg_hit_o)
  );

  irq_gateway #(.NSRC(NSRC)) u_gw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .clr_pend_i (clr_pend),
    .clr_mask_i (clr_mask),
    .pend_q     (pend_q),
    .pend_upd_o (pend_upd)
  );

  irq_pick #(.NSRC(NSRC)) u_pick (
    .cand_i  (pend_upd & en_q),
    .found_o (cl_found),
    .id_o    (cl_id)
  );

  assign clr_pend = (reg_rd_i && sel == SEL_CLAIM && cl_found) ? (NSRC'(1) << cl_id) : '0;

  // completion: number must fit the source range and the source must be enabled
  assign cpl_id   = reg_wdata_i[ID_W-1:0];
  assign cpl_ok   = reg_wr_i && sel == SEL_CLAIM &&
                    reg_wdata_i[DATA_W-1:ID_W] == '0 && en_q[cpl_id];
  assign clr_mask = cpl_ok ? (NSRC'(1) << cpl_id) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (reg_wr_i && sel == SEL_EN) begin
      en_q <= reg_wdata_i[NSRC-1:0] & {{(NSRC-1){1'b1}}, 1'b0};
    end
  end

  always_comb begin
    unique case (sel)
      SEL_PRIO:  reg_rdata_o = DATA_W'(1);
      SEL_PEND:  reg_rdata_o = DATA_W'(pend_q);
      SEL_EN:    reg_rdata_o = DATA_W'(en_q);
      SEL_CLAIM: reg_rdata_o = cl_found ? DATA_W'(cl_id) : '0;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign ext_irq_o = |(pend_q & en_q);
endmodule

// File: rtl/irq_ctrl_lite_chk.sv
module irq_ctrl_lite_chk
  import irq_lite_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ID_W  = $clog2(NSRC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   src_i,
  input logic [IDX_W-1:0]  reg_idx_i,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              ext_irq_o,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   mask_q
);
  logic claim_rd;
  logic cpl_wr;
  assign claim_rd = reg_rd_i && reg_idx_i == IDX_CLAIM;
  assign cpl_wr   = reg_wr_i && reg_idx_i == IDX_CLAIM;

  // R5: a newly pending bit needs its input high in the previous cycle
  a_r5_pend_needs_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(src_i)) == '0));

  // R6: a masked source does not turn pending
  a_r6_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & $past(mask_q)) == '0));

  // R5: without a completion, every high input is masked at the next edge
  a_r5_mask_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpl_wr |=> ((mask_q & $past(src_i)) == $past(src_i)));

  // R7: a granted claim leaves that source not pending
  a_r7_claim_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_rd && reg_rdata_o != '0) |=> !pend_q[$past(reg_rdata_o[ID_W-1:0])]);

  // R9: with the request raised, a claim cannot come back empty
  a_r9_irq_claimable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_irq_o && claim_rd) |-> reg_rdata_o != '0);

  // R4: source 0 can never be enabled
  a_r4_en_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q[0]);
endmodule

bind irq_ctrl_lite irq_ctrl_lite_chk #(.NSRC(NSRC), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .reg_idx_i   (reg_idx_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rdata_o (reg_rdata_o),
  .ext_irq_o   (ext_irq_o),
  .pend_q      (pend_q),
  .en_q        (en_q),
  .mask_q      (u_gw.mask_q)
);

// File: tb/tb_irq_ctrl_lite.sv
module tb_irq_ctrl_lite;
  localparam logic [19:0] I_PEND  = 20'h00400;
  localparam logic [19:0] I_EN    = 20'h00800;
  localparam logic [19:0] I_THR   = 20'h80000;
  localparam logic [19:0] I_CLAIM = 20'h80001;

  // {index, expected hit, expected read data}, walked right after reset
  localparam int NVEC = 12;
  localparam logic [52:0] VEC [NVEC] = '{
    {20'h00001, 1'b1, 32'h1},
    {20'h00010, 1'b1, 32'h1},
    {20'h0001F, 1'b1, 32'h1},
    {20'h00000, 1'b0, 32'h0},
    {20'h00020, 1'b0, 32'h0},
    {20'h003FF, 1'b0, 32'h0},
    {20'h00400, 1'b1, 32'h0},
    {20'h00800, 1'b1, 32'h0},
    {20'h80000, 1'b1, 32'h0},
    {20'h80001, 1'b1, 32'h0},
    {20'h80002, 1'b0, 32'h0},
    {20'h7FFFF, 1'b0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src = '0;
  logic [19:0] idx = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        hit;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl_lite dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .src_i       (src),
    .reg_idx_i   (idx),
    .reg_rd_i    (rd),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .reg_hit_o   (hit),
    .ext_irq_o   (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [19:0] i, output logic [31:0] d, output logic h);
    @(negedge clk);
    idx = i; rd = 1'b1;
    #1 d = rdata; h = hit;
    @(posedge clk);
    #1 rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [19:0] i, input logic [31:0] d);
    @(negedge clk);
    idx = i; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk) src = v;
    @(negedge clk) src = '0;
  endtask

  task automatic expect_rd(input string req, input logic [19:0] i, input logic [31:0] exp);
    logic [31:0] d;
    logic h;
    bus_rd(i, d, h);
    chk(req, d, exp);
  endtask

  task automatic expect_irq(input string req, input logic exp);
    @(negedge clk);
    #1 chk(req, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic h;

    repeat (3) @(negedge clk);
    #1 chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst_ni = 1'b1;
    expect_irq("R1 irq after reset", 1'b0);

    // R2 R3 R4 R7: decode table straight out of reset
    for (int k = 0; k < NVEC; k++) begin
      bus_rd(VEC[k][52:33], d, h);
      chk("R2 hit", {31'b0, h}, {31'b0, VEC[k][32]});
      chk("R2 R3 rdata", d, VEC[k][31:0]);
    end

    // R3: fixed words drop writes
    bus_wr(20'h00005, 32'h7);
    expect_rd("R3 prio write ignored", 20'h00005, 32'h1);
    bus_wr(I_THR, 32'hFF);
    expect_rd("R3 threshold write ignored", I_THR, 32'h0);

    // R4: bit 0 of enable is forced low
    bus_wr(I_EN, 32'hFFFF_FFFF);
    expect_rd("R4 enable readback", I_EN, 32'hFFFF_FFFE);

    // R5 R7 R9: two sources, lowest first
    pulse(32'h28);
    expect_irq("R9 irq high", 1'b1);
    expect_rd("R5 pending set", I_PEND, 32'h28);
    expect_rd("R7 claim lowest", I_CLAIM, 32'd3);
    expect_rd("R7 claim clears", I_PEND, 32'h20);
    expect_rd("R7 claim next", I_CLAIM, 32'd5);
    expect_rd("R7 empty claim", I_CLAIM, 32'd0);
    expect_irq("R9 irq low", 1'b0);

    // R6 R10: held line stays silent until completion, then one edge later
    @(negedge clk) src = 32'h8;
    repeat (3) @(negedge clk);
    expect_rd("R6 masked held source", I_PEND, 32'h0);
    bus_wr(I_CLAIM, 32'd3);
    expect_rd("R10 not pending at completion edge", I_PEND, 32'h0);
    expect_rd("R10 pending one edge later", I_PEND, 32'h8);
    expect_rd("R7 claim held source", I_CLAIM, 32'd3);
    @(negedge clk) src = '0;

    // R8: out-of-range completion value is dropped
    bus_wr(I_CLAIM, 32'd35);
    pulse(32'h8);
    expect_rd("R8 value 35 ignored", I_PEND, 32'h0);
    bus_wr(I_CLAIM, 32'd3);
    pulse(32'h8);
    expect_rd("R8 valid completion", I_PEND, 32'h8);
    expect_rd("R7 claim 3", I_CLAIM, 32'd3);

    // R7 R9: pending but disabled source
    bus_wr(I_CLAIM, 32'd5);
    bus_wr(I_EN, 32'hFFFF_FFDF);
    pulse(32'h20);
    expect_irq("R9 disabled pending no irq", 1'b0);
    expect_rd("R7 disabled not claimed", I_CLAIM, 32'd0);
    expect_rd("R5 pending regardless of enable", I_PEND, 32'h20);
    bus_wr(I_EN, 32'hFFFF_FFFF);
    expect_irq("R9 irq on enable", 1'b1);
    expect_rd("R7 claim after enable", I_CLAIM, 32'd5);

    // R8: completion of a disabled source leaves mask set
    bus_wr(I_EN, 32'hFFFF_FFDF);
    bus_wr(I_CLAIM, 32'd5);
    bus_wr(I_EN, 32'hFFFF_FFFF);
    pulse(32'h20);
    expect_rd("R8 disabled completion ignored", I_PEND, 32'h0);
    bus_wr(I_CLAIM, 32'd5);
    pulse(32'h20);
    expect_rd("R8 enabled completion", I_PEND, 32'h20);
    expect_rd("R7 claim 5", I_CLAIM, 32'd5);

    // R5: source 0 never pending
    pulse(32'h1);
    expect_rd("R5 source 0", I_PEND, 32'h0);
    expect_irq("R5 source 0 no irq", 1'b0);

    // R7: spread sources
    pulse(32'h8002_0004);
    expect_rd("R7 spread a", I_CLAIM, 32'd2);
    expect_rd("R7 spread b", I_CLAIM, 32'd17);
    expect_rd("R7 spread c", I_CLAIM, 32'd31);
    expect_rd("R7 spread empty", I_CLAIM, 32'd0);

    // R10: claim in the same cycle the input rises
    @(negedge clk);
    src = 32'h200; idx = I_CLAIM; rd = 1'b1;
    #1 chk("R10 same-cycle claim", rdata, 32'd9);
    @(posedge clk);
    #1 rd = 1'b0;
    @(negedge clk) src = '0;
    expect_rd("R10 same-cycle claim cleared", I_PEND, 32'h0);

    // R1: mid-run reset clears enable, pending and mask
    pulse(32'h10);
    expect_irq("R9 before reset", 1'b1);
    @(negedge clk) rst_ni = 1'b0;
    #1 chk("R1 irq during reset", {31'b0, irq}, 32'h0);
    @(negedge clk) rst_ni = 1'b1;
    expect_rd("R1 enable cleared", I_EN, 32'h0);
    expect_rd("R1 pending cleared", I_PEND, 32'h0);
    pulse(32'h200);
    expect_rd("R1 mask cleared", I_PEND, 32'h200);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule